// File: doc/BRIEF.md
# Pin Sense Event Generator

This block watches a bank of general-purpose input pins and turns changes or levels on them into event pulses, one event line per pin. Each pin has its own two-bit sense setting: both edges, rising edge, falling edge, or high level. Each pin also has an invert bit. The pins are asynchronous to the block. Each one is XORed with its invert bit and then passes through a multi-flop synchronizer in the peripheral clock domain. The last synchronizer stage is compared against a one-sample history flop. All pins are evaluated in parallel on the same clock edge.

A clock-enable input stands for the peripheral clock. The synchronizer, the history flops and the startup counter advance only on enabled cycles. A cycle without the enable drives every event line low, so no event can be produced without the peripheral clock. A pin change that is made and undone between two enabled samples is never seen. The event lines are plain control outputs. They are single-cycle pulses with no handshake and no back-pressure, and a consumer that misses a pulse loses it.

Top module: `pin_sense_evgen`

## Requirements
- R1: With mode code 2'b01 (rising), a pin's event fires for exactly one cycle when its sensed value (pin XOR invert) goes from 0 to 1 between two enabled samples, and never in any other case.
- R2: With mode code 2'b10 (falling), a pin's event fires for exactly one cycle when its sensed value goes from 1 to 0 between two enabled samples, and never in any other case.
- R3: With mode code 2'b00 (both edges), a pin's event fires for one cycle on every change of its sensed value between two enabled samples.
- R4: With mode code 2'b11 (level), a sensed 1 raises the event on every enabled cycle and a sensed 0 never raises it.
- R5: Inversion is applied before synchronization. An inverted pin held low gives level events. Toggling the invert bit on a static pin gives one edge event. Flipping the pin and the invert bit together gives no event.
- R6: A sensed value that is present at enabled edge k shows on the event output just after enabled edge k+2, counted in enabled edges (with the default two synchronizer stages).
- R7: On a cycle with clk_en low, every event output is 0 on the following cycle. Synchronizer and history state hold on such a cycle, so a change made and undone while the enable is low produces no event.
- R8: Synchronous reset clears all state and drives every event output to 0. No event is produced during the first three enabled cycles after reset, so the first sample never makes a spurious edge.
- R9: Pins are independent. Each pin's event depends only on its own pin, invert bit and mode, including when the pins have mixed modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Peripheral clock enable; nothing advances and no event is produced while low |
| pin_raw_i | input | N_PINS | Asynchronous pin inputs |
| pin_inv_i | input | N_PINS | Per-pin invert bit |
| pin_mode_i | input | 2*N_PINS | Per-pin sense mode, bits [2i+1:2i] for pin i: 00 both, 01 rise, 10 fall, 11 level |
| pin_evt_o | output | N_PINS | Per-pin event pulse |

## Verification
The invert path and the pin path meet at the same XOR, so a pin change and an invert toggle can land on the same sample. The bench drives both in one cycle on a static bank in both-edge mode. Since the sensed value does not change, it judges that no event appears. The bench also drops clk_en while an edge is travelling through the synchronizer. It checks that the event is suppressed on the disabled cycle and that the edge is delivered late rather than lost. Throughout, a bench model of sampled values, indexed by enabled-edge count, supplies the expected event vector for every cycle of constrained-random traffic.

// File: rtl/pse_pkg.sv
package pse_pkg;
  typedef enum logic [1:0] {
    SNS_BOTH  = 2'b00,
    SNS_RISE  = 2'b01,
    SNS_FALL  = 2'b10,
    SNS_LEVEL = 2'b11
  } sense_mode_e;
endpackage

// File: rtl/pse_sync.sv
// Multi-stage synchronizer that advances only on enabled cycles.
module pse_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else if (en) begin
      for (int s = STAGES - 1; s > 0; s--) stg[s] <= stg[s-1];
      stg[0] <= d;
    end
  end

  assign q = stg[STAGES-1];

  AST_SYNC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !en |=> (q == $past(q))); // R7
endmodule

// File: rtl/pse_warmup.sv
// Counts enabled cycles after reset until the sample history is valid.
module pse_warmup #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic ready
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] LAST = CW'(DEPTH);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (en && cnt != LAST)  cnt <= cnt + 1'b1;
  end

  assign ready = (cnt == LAST);

  AST_WARM_STAYS: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready); // R8
endmodule

// File: rtl/pse_detect.sv
// Per-pin sense decoder with history flop and registered event.
module pse_detect
  import pse_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic        ready,
  input  sense_mode_e mode,
  input  logic        cur,
  output logic        evt_o
);
  logic prev_q;
  logic evt_q;
  logic hit;

  always_comb begin
    unique case (mode)
      SNS_BOTH:  hit = cur ^ prev_q;
      SNS_RISE:  hit = cur & ~prev_q;
      SNS_FALL:  hit = ~cur & prev_q;
      default:   hit = cur;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      if (en) prev_q <= cur;
      evt_q <= en & ready & hit;
    end
  end

  assign evt_o = evt_q;

  AST_RISE_ONLY_UP: assert property (@(posedge clk) disable iff (rst)
    (evt_q && $past(mode == SNS_RISE)) |-> ($past(cur) && !$past(prev_q))); // R1
  AST_FALL_ONLY_DOWN: assert property (@(posedge clk) disable iff (rst)
    (evt_q && $past(mode == SNS_FALL)) |-> (!$past(cur) && $past(prev_q))); // R2
  AST_LEVEL_LOW_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mode == SNS_LEVEL && !cur) |=> !evt_q); // R4
  AST_LEVEL_HIGH_FIRES: assert property (@(posedge clk) disable iff (rst)
    (en && ready && mode == SNS_LEVEL && cur) |=> evt_q); // R4
endmodule

// File: rtl/pin_sense_evgen.sv
module pin_sense_evgen
  import pse_pkg::*;
#(
  parameter int N_PINS      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clk_en,
  input  logic [N_PINS-1:0]     pin_raw_i,
  input  logic [N_PINS-1:0]     pin_inv_i,
  input  logic [2*N_PINS-1:0]   pin_mode_i,
  output logic [N_PINS-1:0]     pin_evt_o
);
  localparam int WARM_DEPTH = SYNC_STAGES + 1;

  logic [N_PINS-1:0] sensed_raw;
  logic [N_PINS-1:0] sensed_sync;
  logic              hist_ready;

  // inversion precedes the synchronizer, so an invert toggle is a real edge
  assign sensed_raw = pin_raw_i ^ pin_inv_i;

  pse_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .en(clk_en), .d(sensed_raw), .q(sensed_sync)
  );

  pse_warmup #(.DEPTH(WARM_DEPTH)) u_warm (
    .clk(clk), .rst(rst), .en(clk_en), .ready(hist_ready)
  );

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    pse_detect u_det (
      .clk(clk), .rst(rst), .en(clk_en), .ready(hist_ready),
      .mode(sense_mode_e'(pin_mode_i[2*g +: 2])),
      .cur(sensed_sync[g]), .evt_o(pin_evt_o[g])
    );
  end

  AST_NO_EVT_WO_CLK: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> (pin_evt_o == '0)); // R7
  AST_QUIET_WARMUP: assert property (@(posedge clk) disable iff (rst)
    !hist_ready |=> (pin_evt_o == '0)); // R8
endmodule

// File: tb/pin_sense_evgen_bench.sv
module pin_sense_evgen_bench;
  localparam int N  = 8;
  localparam int ST = 2;

  logic           clk = 1'b0;
  logic           rst;
  logic           clk_en;
  logic [N-1:0]   pins;
  logic [N-1:0]   inv;
  logic [2*N-1:0] mode;
  logic [N-1:0]   evt;

  always #10 clk = ~clk;

  pin_sense_evgen #(.N_PINS(N), .SYNC_STAGES(ST)) u_pin_sense_evgen (
    .clk(clk), .rst(rst), .clk_en(clk_en), .pin_raw_i(pins),
    .pin_inv_i(inv), .pin_mode_i(mode), .pin_evt_o(evt)
  );

  int checks = 0;
  int fails  = 0;
  int nen    = 0;
  bit done   = 1'b0;
  logic [N-1:0] vs [0:ST];

  function automatic logic [N-1:0] model_evt(input logic [2*N-1:0] m,
                                             input logic [N-1:0] cur,
                                             input logic [N-1:0] prev);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      case (m[2*i +: 2])
        2'b00:   r[i] = cur[i] ^ prev[i];
        2'b01:   r[i] = cur[i] & ~prev[i];
        2'b10:   r[i] = ~cur[i] & prev[i];
        default: r[i] = cur[i];
      endcase
    end
    return r;
  endfunction

  task automatic step(input string tag);
    logic [N-1:0] e;
    e = '0;
    if (rst) begin
      nen = 0;
      for (int k = 0; k <= ST; k++) vs[k] = '0;
    end else if (clk_en) begin
      if (nen + 1 >= ST + 2) e = model_evt(mode, vs[ST-1], vs[ST]);
      for (int k = ST; k > 0; k--) vs[k] = vs[k-1];
      vs[0] = pins ^ inv;
      nen++;
    end
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (evt !== e) begin
      fails++;
      $display("FAIL %s: evt=%b expected %b", tag, evt, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog: run not done, expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    rst = 1'b1; clk_en = 1'b1; pins = '1; inv = '0; mode = '1;
    @(negedge clk);
    step("R8"); step("R8");
    rst = 1'b0;
    repeat (6) step("R8");                 // level high: quiet for 3 enabled cycles
    pins = 8'hA5; repeat (4) step("R4");
    pins = 8'h00; repeat (4) step("R4");
    mode = {N{2'b01}}; repeat (4) step("R1");
    pins = 8'h0F; repeat (4) step("R6");   // edge lands two enabled edges later
    pins = 8'h00; repeat (4) step("R1");   // falling ignored in rise mode
    mode = {N{2'b10}}; pins = 8'hFF; repeat (4) step("R2");
    pins = 8'h3C; repeat (4) step("R2");
    mode = {N{2'b00}}; pins = 8'hFF; repeat (4) step("R3");
    pins = 8'h3C; step("R3"); pins = 8'hC3; repeat (4) step("R3");
    mode = {N{2'b11}}; inv = '1; pins = 8'h00; repeat (5) step("R5");
    mode = {N{2'b00}}; pins = 8'h55; repeat (4) step("R5");
    inv = '0; repeat (4) step("R5");       // invert toggle on static pins
    pins = ~pins; inv = '1; repeat (4) step("R5");  // cancelling flips
    mode = {N{2'b11}}; inv = '0; pins = '1;
    clk_en = 1'b0; repeat (3) step("R7");
    clk_en = 1'b1; repeat (3) step("R7");
    mode = {N{2'b00}};
    clk_en = 1'b0; pins = '0; step("R7"); pins = '1; step("R7");
    clk_en = 1'b1; repeat (4) step("R7");
    pins = 8'h00; step("R7"); clk_en = 1'b0; step("R7"); step("R7");
    clk_en = 1'b1; repeat (4) step("R7"); // edge delayed, not lost
    mode = 16'b11_10_01_00_11_10_01_00;
    for (int i = 0; i < 3000; i++) begin
      clk_en = ($urandom % 5) != 0;
      pins   = pins ^ N'($urandom & $urandom);
      if ($urandom % 16 == 0) inv  = N'($urandom);
      if ($urandom % 64 == 0) mode = 16'($urandom);
      rst = ($urandom % 400) == 0;
      step("R9");
    end
    rst = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule